// File: doc/BRIEF.md
# Call, Interrupt and Return Stack Sequencer

This block carries out the subroutine call, software interrupt and return instructions of a small core whose data memory is four bits wide. The return address is 16 bits, so a call saves it as four nibbles in a call-stack area. A stack pointer addresses that area in units of four nibbles. A second pointer addresses a separate one-nibble-per-entry stack that holds the flag register. The sequencer owns the program counter, both stack pointers, the flag nibble and the data pointer used by the return-with-data variant. It reaches memory through a single nibble port with one access per clock.

Instructions arrive on a valid/ready command channel. `cmd_ready` is high only while the sequencer is idle. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. The sender must hold `cmd_op`, `cmd_imm` and `ext_imm` stable until then. After acceptance `cmd_ready` stays low for one cycle per memory access of that instruction. The architectural registers change only on the edge where `cmd_ready` rises again. The memory port is a plain asynchronous-read port: `mem_rdata` must reflect `mem_addr` in the same cycle, and a write happens at the clock edge while `mem_we` is high.

The extension prefix is modelled by the E flag. When E is set, a relative call takes a 16-bit displacement whose upper byte comes from `ext_imm`. Every instruction of the group except return-from-interrupt clears E.

Top module: `callret_seq`

## Requirements
- R1: Opcodes on `cmd_op` are 0 zero-page call, 1 relative call, 2 memory-offset call, 3 software interrupt, 4 return, 5 return-and-skip, 6 return-with-data, 7 return-from-interrupt. After acceptance `cmd_ready` stays low for 4, 4, 5, 5, 4, 4, 6 and 5 cycles respectively. `mem_we` is only high while `cmd_ready` is low.
- R2: Every call (opcodes 0 to 3) decrements SP1 and writes nibble k (bits 4k+3..4k) of PC+1 to address (SP1-1)×4+k. The writes go in ascending k, so the lowest address holds bits 3..0.
- R3: The zero-page call loads PC with `cmd_imm` zero-extended.
- R4: With E clear, the relative call loads PC+sign-extended `cmd_imm`+1. With E set, the displacement is the signed 16-bit value {`ext_imm`, `cmd_imm`}.
- R5: The memory-offset call reads the nibble at address `cmd_imm[5:0]` and loads PC+nibble+1.
- R6: The software interrupt first writes F to address SP2-1 and decrements SP2. It then pushes PC+1 as in R2 and loads PC with 0100h + `cmd_imm[5:0]`.
- R7: A return loads PC from the four nibbles at SP1×4+k (nibble k at offset k) and increments SP1.
- R8: Return-and-skip loads the popped address plus 1.
- R9: Return-with-data pops PC as in R7. It then writes `cmd_imm[3:0]` to address X and `cmd_imm[7:4]` to X+1, and adds 2 to X.
- R10: Return-from-interrupt pops PC as in R7, then loads F from address SP2 and increments SP2.
- R11: F holds Z in bit 0, C in bit 1, E in bit 2 and I in bit 3. Only return-from-interrupt changes Z, C and I. All other opcodes clear E.
- R12: After reset PC=0, SP1=`SP1_RST`, SP2=`SP2_RST`, X=0, F=0, `cmd_ready`=1 and `mem_we`=0.
- R13: PC arithmetic wraps modulo 2^16, and both stack pointers wrap modulo 2^width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken when both high |
| cmd_op | input | 3 | Opcode (see R1) |
| cmd_imm | input | 8 | Immediate or relative displacement |
| ext_imm | input | 8 | Upper displacement byte used when E is set |
| mem_addr | output | ADDR_W | Nibble memory address |
| mem_wdata | output | 4 | Nibble write data |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 4 | Nibble read data for `mem_addr` |
| pc_o | output | 4×PC_NIBS | Program counter |
| sp1_o | output | SP1_W | Call stack pointer |
| sp2_o | output | SP2_W | Flag stack pointer |
| flags_o | output | 4 | Flag nibble {I,E,C,Z} |
| x_o | output | ADDR_W | Data pointer |

## Verification
The bench sweeps every immediate of the zero-page, relative and data-store forms, every zero-page offset of the interrupt, and every flag nibble through interrupt and return-from-interrupt pairs. It aims at the sign boundary 7Fh/80h: a design that zero-extends the displacement jumps forward 256 too far. It also checks that the extended displacement takes its upper byte from `ext_imm` only while E is set, and that E is cleared again by the next call. The nibble order on the stack is checked by inspecting memory: a reversed order still returns correctly but leaves bytes swapped in memory. The remaining targets are wraparound of SP1 from 0 and of PC from FFFFh on return-and-skip, and the order of the two stack accesses in return-from-interrupt, where reading SP2 before the pop would restore the wrong flags after an interrupt.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [2:0] {
    OP_CALZ = 3'd0,
    OP_CALR = 3'd1,
    OP_CALM = 3'd2,
    OP_SWI  = 3'd3,
    OP_RET  = 3'd4,
    OP_RETS = 3'd5,
    OP_RETD = 3'd6,
    OP_RETI = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OFFR,
    PH_FLAGW,
    PH_PUSH,
    PH_POP,
    PH_DATW,
    PH_FLAGR
  } ph_e;

  localparam int NIB_W = 4;
  localparam int ZP_W  = 6;
  localparam int FLG_Z = 0;
  localparam int FLG_C = 1;
  localparam int FLG_E = 2;
  localparam int FLG_I = 3;

endpackage

// File: rtl/callret_target.sv
module callret_target
  import callret_pkg::*;
#(
  parameter int PC_W = 16,
  parameter logic [15:0] SWI_BASE = 16'h0100
) (
  input  op_e             op,
  input  logic [PC_W-1:0] pc,
  input  logic [7:0]      imm8,
  input  logic [7:0]      ext8,
  input  logic            ext_en,
  input  logic [3:0]      off_nib,
  input  logic [PC_W-1:0] popped,
  output logic [PC_W-1:0] target
);

  logic [PC_W-1:0] disp;
  logic [PC_W-1:0] one;

  assign one = PC_W'(1);

  // R4: short displacement sign-extends; prefixed form is a signed 16-bit value
  always_comb begin
    if (ext_en) disp = PC_W'($signed({ext8, imm8}));
    else        disp = PC_W'($signed(imm8));
  end

  always_comb begin
    case (op)
      OP_CALZ: target = PC_W'(imm8);                                   // R3
      OP_CALR: target = pc + disp + one;                               // R4
      OP_CALM: target = pc + PC_W'(off_nib) + one;                     // R5
      OP_SWI:  target = PC_W'(SWI_BASE) + PC_W'(imm8[ZP_W-1:0]);       // R6
      OP_RETS: target = popped + one;                                  // R8
      default: target = popped;                                        // R7, R9, R10
    endcase
  end

endmodule

// File: rtl/callret_addr.sv
module callret_addr
  import callret_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SP1_W  = 8,
  parameter int SP2_W  = 8,
  parameter int IDX_W  = 2
) (
  input  ph_e               phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SP1_W-1:0]  sp1,
  input  logic [SP2_W-1:0]  sp2,
  input  logic [ADDR_W-1:0] x,
  input  logic [ZP_W-1:0]   zp,
  output logic [ADDR_W-1:0] addr
);

  logic [SP1_W-1:0]  sp1_dec;
  logic [SP2_W-1:0]  sp2_dec;
  logic [ADDR_W-1:0] push_base;
  logic [ADDR_W-1:0] pop_base;

  assign sp1_dec   = sp1 - SP1_W'(1);
  assign sp2_dec   = sp2 - SP2_W'(1);
  // frames are aligned to the nibble count, so offset k is simply OR-ed in
  assign push_base = ADDR_W'({sp1_dec, {IDX_W{1'b0}}});
  assign pop_base  = ADDR_W'({sp1, {IDX_W{1'b0}}});

  always_comb begin
    case (phase)
      PH_OFFR:  addr = ADDR_W'(zp);
      PH_FLAGW: addr = ADDR_W'(sp2_dec);
      PH_PUSH:  addr = push_base | ADDR_W'(idx);
      PH_POP:   addr = pop_base | ADDR_W'(idx);
      PH_DATW:  addr = x + ADDR_W'(idx);
      PH_FLAGR: addr = ADDR_W'(sp2);
      default:  addr = '0;
    endcase
  end

endmodule

// File: rtl/callret_popasm.sv
module callret_popasm
  import callret_pkg::*;
#(
  parameter int NIBS  = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic [NIB_W-1:0]      rdata,
  output logic [NIBS*NIB_W-1:0] value
);

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [NIB_W-1:0] held;
    logic             hit;

    assign hit = cap_en && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held <= '0;
      else if (hit) held <= rdata;
    end

    // the nibble being read this cycle is forwarded so the final pop can commit at once
    assign value[g*NIB_W +: NIB_W] = hit ? rdata : held;
  end

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          SP1_W    = 8,
  parameter int          SP2_W    = 8,
  parameter int          PC_NIBS  = 4,
  parameter logic [SP1_W-1:0] SP1_RST = '0,
  parameter logic [SP2_W-1:0] SP2_RST = '0,
  parameter logic [15:0] SWI_BASE = 16'h0100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [2:0]                cmd_op,
  input  logic [7:0]                cmd_imm,
  input  logic [7:0]                ext_imm,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [3:0]                mem_wdata,
  output logic                      mem_we,
  input  logic [3:0]                mem_rdata,
  output logic [PC_NIBS*4-1:0]      pc_o,
  output logic [SP1_W-1:0]          sp1_o,
  output logic [SP2_W-1:0]          sp2_o,
  output logic [3:0]                flags_o,
  output logic [ADDR_W-1:0]         x_o
);

  localparam int PC_W  = PC_NIBS * NIB_W;
  localparam int IDX_W = (PC_NIBS > 2) ? $clog2(PC_NIBS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PC_NIBS - 1);

  ph_e               phase;
  op_e               cur_op;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        cur_imm;
  logic [7:0]        cur_ext;
  logic [3:0]        off_nib;
  logic [PC_W-1:0]   ret_addr;
  logic [PC_W-1:0]   pc_q;
  logic [SP1_W-1:0]  sp1_q;
  logic [SP2_W-1:0]  sp2_q;
  logic [ADDR_W-1:0] x_q;
  logic [3:0]        flags_q;
  logic [PC_W-1:0]   popped;
  logic [PC_W-1:0]   target;
  logic              accept;
  logic              idx_last;
  logic              commit;
  logic              is_call;

  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign idx_last  = (idx == IDX_LAST);
  assign is_call   = (cur_op == OP_CALZ) || (cur_op == OP_CALR) ||
                     (cur_op == OP_CALM) || (cur_op == OP_SWI);

  // the edge that finishes the last access of the instruction updates the registers
  always_comb begin
    case (phase)
      PH_PUSH:  commit = idx_last;
      PH_POP:   commit = idx_last && (cur_op != OP_RETD) && (cur_op != OP_RETI);
      PH_DATW:  commit = (idx == IDX_W'(1));
      PH_FLAGR: commit = 1'b1;
      default:  commit = 1'b0;
    endcase
  end

  function automatic ph_e first_phase(op_e o);
    case (o)
      OP_CALZ, OP_CALR: return PH_PUSH;
      OP_CALM:          return PH_OFFR;
      OP_SWI:           return PH_FLAGW;
      default:          return PH_POP;
    endcase
  endfunction

  // ---------------- sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cur_op   <= OP_RET;
      idx      <= '0;
      cur_imm  <= '0;
      cur_ext  <= '0;
      off_nib  <= '0;
      ret_addr <= '0;
    end else if (accept) begin
      cur_op   <= op_e'(cmd_op);
      cur_imm  <= cmd_imm;
      cur_ext  <= ext_imm;
      ret_addr <= pc_q + PC_W'(1);
      idx      <= '0;
      phase    <= first_phase(op_e'(cmd_op));
    end else begin
      case (phase)
        PH_OFFR: begin
          off_nib <= mem_rdata;
          phase   <= PH_PUSH;
        end
        PH_FLAGW: phase <= PH_PUSH;
        PH_PUSH: begin
          idx <= idx + IDX_W'(1);
          if (idx_last) phase <= PH_IDLE;
        end
        PH_POP: begin
          idx <= idx_last ? '0 : idx + IDX_W'(1);
          if (idx_last) begin
            if (cur_op == OP_RETD)      phase <= PH_DATW;
            else if (cur_op == OP_RETI) phase <= PH_FLAGR;
            else                        phase <= PH_IDLE;
          end
        end
        PH_DATW: begin
          idx <= idx + IDX_W'(1);
          if (idx == IDX_W'(1)) phase <= PH_IDLE;
        end
        PH_FLAGR: phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  // ---------------- architectural registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      sp1_q   <= SP1_RST;
      sp2_q   <= SP2_RST;
      x_q     <= '0;
      flags_q <= '0;
    end else if (commit) begin
      pc_q  <= target;
      sp1_q <= is_call ? sp1_q - SP1_W'(1) : sp1_q + SP1_W'(1);
      if (cur_op == OP_SWI)  sp2_q <= sp2_q - SP2_W'(1);
      if (cur_op == OP_RETI) sp2_q <= sp2_q + SP2_W'(1);
      if (cur_op == OP_RETD) x_q   <= x_q + ADDR_W'(2);
      if (cur_op == OP_RETI) flags_q <= mem_rdata;
      else                   flags_q[FLG_E] <= 1'b0;
    end
  end

  // ---------------- memory port ----------------
  assign mem_we = (phase == PH_FLAGW) || (phase == PH_PUSH) || (phase == PH_DATW);

  always_comb begin
    case (phase)
      PH_FLAGW: mem_wdata = flags_q;
      PH_PUSH:  mem_wdata = ret_addr[idx*NIB_W +: NIB_W];
      PH_DATW:  mem_wdata = (idx == IDX_W'(0)) ? cur_imm[3:0] : cur_imm[7:4];
      default:  mem_wdata = '0;
    endcase
  end

  callret_addr #(
    .ADDR_W(ADDR_W), .SP1_W(SP1_W), .SP2_W(SP2_W), .IDX_W(IDX_W)
  ) u_addr (
    .phase(phase), .idx(idx), .sp1(sp1_q), .sp2(sp2_q), .x(x_q),
    .zp(cur_imm[ZP_W-1:0]), .addr(mem_addr)
  );

  callret_popasm #(
    .NIBS(PC_NIBS), .IDX_W(IDX_W)
  ) u_pop (
    .clk(clk), .rst_n(rst_n), .cap_en(phase == PH_POP), .idx(idx),
    .rdata(mem_rdata), .value(popped)
  );

  callret_target #(
    .PC_W(PC_W), .SWI_BASE(SWI_BASE)
  ) u_tgt (
    .op(cur_op), .pc(pc_q), .imm8(cur_imm), .ext8(cur_ext),
    .ext_en(flags_q[FLG_E]), .off_nib(off_nib), .popped(popped),
    .target(target)
  );

  assign pc_o    = pc_q;
  assign sp1_o   = sp1_q;
  assign sp2_o   = sp2_q;
  assign flags_o = flags_q;
  assign x_o     = x_q;

  // ---------------- assertions ----------------
  p_we_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !cmd_ready);

  p_pc_hold_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> $stable(pc_o));

  p_sp1_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp1_o) |-> ((sp1_o == SP1_W'($past(sp1_o) + SP1_W'(1))) ||
                         (sp1_o == SP1_W'($past(sp1_o) - SP1_W'(1)))));

  p_sp2_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp2_o) |-> ((sp2_o == SP2_W'($past(sp2_o) + SP2_W'(1))) ||
                         (sp2_o == SP2_W'($past(sp2_o) - SP2_W'(1)))));

  p_x_by_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(x_o) |-> (x_o == ADDR_W'($past(x_o) + ADDR_W'(2))));

  p_flags_only_reti_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({flags_o[FLG_I], flags_o[FLG_C], flags_o[FLG_Z]}) |-> ($past(cur_op) == OP_RETI));

  p_e_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_ready) && ($past(cur_op) != OP_RETI)) |-> !flags_o[FLG_E]);

endmodule

// File: tb/tb_callret_seq.sv
`timescale 1ns/1ps
module tb_callret_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_imm = '0;
  logic [7:0]  ext_imm = '0;
  logic [15:0] mem_addr;
  logic [3:0]  mem_wdata;
  logic        mem_we;
  logic [3:0]  mem_rdata;
  logic [15:0] pc_o;
  logic [7:0]  sp1_o;
  logic [7:0]  sp2_o;
  logic [3:0]  flags_o;
  logic [15:0] x_o;

  always #2 clk = ~clk;

  callret_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_imm(cmd_imm), .ext_imm(ext_imm),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .sp1_o(sp1_o), .sp2_o(sp2_o), .flags_o(flags_o), .x_o(x_o)
  );

  logic [3:0] mem [0:65535];
  int wcount = 0;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    wcount <= wcount + 1;
  end

  int checks = 0;
  int errors = 0;

  logic [15:0] m_pc = '0, m_x = '0;
  logic [7:0]  m_sp1 = '0, m_sp2 = '0;
  logic [3:0]  m_f = '0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
    end
  endtask

  function automatic logic [15:0] stack_val(logic [7:0] sp);
    logic [15:0] v;
    for (int k = 0; k < 4; k++) v[k*4 +: 4] = mem[{6'b0, sp, 2'(k)}];
    return v;
  endfunction

  task automatic set_stack(logic [15:0] v);
    for (int k = 0; k < 4; k++) mem[{6'b0, m_sp1, 2'(k)}] = v[k*4 +: 4];
  endtask

  task automatic run_op(int op, logic [7:0] imm, logic [7:0] ext);
    logic [15:0] ret, disp, popped, e_pc, e_x;
    logic [7:0]  e_sp1, e_sp2;
    logic [3:0]  e_f;
    int          e_cyc, e_w, cyc;
    string       tg;
    ret    = m_pc + 16'd1;
    popped = stack_val(m_sp1);
    e_pc = m_pc; e_sp1 = m_sp1; e_sp2 = m_sp2; e_x = m_x;
    e_f  = m_f & 4'b1011;
    e_w  = 0;
    case (op)
      0: begin e_pc = {8'h00, imm}; e_sp1 = m_sp1 - 8'd1; e_cyc = 4; e_w = 4; tg = "R3"; end
      1: begin
        disp = m_f[2] ? {ext, imm} : {{8{imm[7]}}, imm};
        e_pc = m_pc + disp + 16'd1; e_sp1 = m_sp1 - 8'd1; e_cyc = 4; e_w = 4; tg = "R4";
      end
      2: begin e_pc = m_pc + {12'h0, mem[{10'b0, imm[5:0]}]} + 16'd1; e_sp1 = m_sp1 - 8'd1;
               e_cyc = 5; e_w = 4; tg = "R5"; end
      3: begin e_pc = 16'h0100 + {10'b0, imm[5:0]}; e_sp1 = m_sp1 - 8'd1; e_sp2 = m_sp2 - 8'd1;
               e_cyc = 5; e_w = 5; tg = "R6"; end
      4: begin e_pc = popped; e_sp1 = m_sp1 + 8'd1; e_cyc = 4; tg = "R7"; end
      5: begin e_pc = popped + 16'd1; e_sp1 = m_sp1 + 8'd1; e_cyc = 4; tg = "R8"; end
      6: begin e_pc = popped; e_sp1 = m_sp1 + 8'd1; e_x = m_x + 16'd2; e_cyc = 6; e_w = 2; tg = "R9"; end
      default: begin e_pc = popped; e_sp1 = m_sp1 + 8'd1; e_f = mem[{8'b0, m_sp2}];
               e_sp2 = m_sp2 + 8'd1; e_cyc = 5; tg = "R10"; end
    endcase

    @(negedge clk);
    check("R1", "ready before command", 32'(cmd_ready), 32'd1);
    wcount    = 0;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_imm = imm; ext_imm = ext;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!cmd_ready && cyc < 50) begin
      cyc++;
      @(negedge clk);
    end
    check("R1", "busy cycles", 32'(cyc), 32'(e_cyc));
    check("R1", "write count", 32'(wcount), 32'(e_w));
    check(tg, "pc", 32'(pc_o), 32'(e_pc));
    check((op < 4) ? "R2" : "R7", "sp1", 32'(sp1_o), 32'(e_sp1));
    check((op == 3) ? "R6" : "R10", "sp2", 32'(sp2_o), 32'(e_sp2));
    check("R9", "x", 32'(x_o), 32'(e_x));
    check((op == 7) ? "R10" : "R11", "flags", 32'(flags_o), 32'(e_f));
    if (op < 4)  check("R2", "pushed return", 32'(stack_val(e_sp1)), 32'(ret));
    if (op == 3) check("R6", "pushed flags", 32'(mem[{8'b0, e_sp2}]), 32'(m_f));
    if (op == 6) begin
      check("R9", "low data nibble", 32'(mem[m_x]), 32'(imm[3:0]));
      check("R9", "high data nibble", 32'(mem[m_x + 16'd1]), 32'(imm[7:4]));
    end
    m_pc = e_pc; m_sp1 = e_sp1; m_sp2 = e_sp2; m_x = e_x; m_f = e_f;
  endtask

  task automatic main_seq();
    for (int a = 0; a < 65536; a++) mem[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "reset pc", 32'(pc_o), 32'd0);
    check("R12", "reset sp1", 32'(sp1_o), 32'd0);
    check("R12", "reset sp2", 32'(sp2_o), 32'd0);
    check("R12", "reset x", 32'(x_o), 32'd0);
    check("R12", "reset flags", 32'(flags_o), 32'd0);
    check("R12", "reset ready", 32'(cmd_ready), 32'd1);
    check("R12", "reset we", 32'(mem_we), 32'd0);

    // first call wraps SP1 from 0 to FFh
    run_op(0, 8'h12, 8'h00);
    check("R13", "sp1 wrap down", 32'(sp1_o), 32'hFF);
    run_op(4, 8'h00, 8'h00);

    for (int i = 0; i < 256; i++) begin
      run_op(0, 8'(i), 8'h00);
      run_op(4, 8'h00, 8'h00);
    end
    for (int i = 0; i < 256; i++) begin
      run_op(1, 8'(i), 8'h00);
      run_op(4, 8'h00, 8'h00);
    end
    // prefixed relative call: E set through return-from-interrupt
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < 3; j++) begin
        set_stack(16'(k * 16'h0F1D + j * 16'h3001));
        mem[{8'b0, m_sp2}] = 4'b0100;
        run_op(7, 8'h00, 8'h00);
        run_op(1, (j == 0) ? 8'h00 : (j == 1) ? 8'h7F : 8'h80, 8'(k * 17));
        run_op(4, 8'h00, 8'h00);
      end
    end
    for (int n = 0; n < 16; n++) begin
      mem[{10'b0, 6'(n * 4 + 3)}] = 4'(n);
      run_op(2, 8'(n * 4 + 3), 8'h00);
      run_op(4, 8'h00, 8'h00);
    end
    for (int i = 0; i < 64; i++) begin
      set_stack(16'(i * 16'h0101));
      mem[{8'b0, m_sp2}] = 4'(i);
      run_op(7, 8'h00, 8'h00);
      run_op(3, 8'(i) | 8'hC0, 8'h00);
      run_op(7, 8'h00, 8'h00);
    end
    // PC wrap on return-and-skip
    set_stack(16'hFFFF);
    run_op(5, 8'h00, 8'h00);
    check("R13", "pc wrap", 32'(pc_o), 32'h0000);
    for (int i = 0; i < 256; i++) begin
      run_op(0, 8'(i), 8'h00);
      run_op(5, 8'h00, 8'h00);
      run_op(0, 8'(255 - i), 8'h00);
      run_op(6, 8'(i), 8'h00);
    end
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule